// File: doc/BRIEF.md
# Mailbox-Driven I2C Register Access Master

This block gives a host a small register window through which it reads or writes a single byte inside an I2C peripheral. The host loads an extension register with the peripheral's internal register address in the low byte and, for writes, the byte to store in the high byte. A single write of a command word then launches the whole bus transaction. While it runs, a busy flag in the status register stays set, and the host polls it before issuing anything new.

A write transaction sends START, the slave address with the write bit, the register address, the data byte and STOP. A read sends START, the slave address with the write bit, the register address, a repeated START, the slave address with the read bit, then clocks in one byte, answers it with a NACK and sends STOP. The byte received appears in the low byte of the read-data register, and a sticky ready flag signals its arrival. If the slave fails to acknowledge any byte the master sends, the transaction is cut short with a STOP and a sticky error flag is raised. Both flags are cleared by writing a one to their bit.

Both bus lines are open-drain: each output enable pulls its line low, and releasing it lets the line float high. The bit rate comes from a divider parameter that sets the length of a quarter bit period.

Top module: `i2c_mailbox_master`

## Requirements
- R1: Status bit 12 (busy) reads 1 from the cycle after an accepted command until the closing STOP finishes, and reads 0 otherwise; after reset every status bit and the read-data register read 0.
- R2: A write to the command register (offset 2) is accepted only when its bits 15:14 are both 1; bits 7:1 give the 7-bit slave address, bit 10 set selects a write and clear selects a read; a command without both start bits leaves the block idle.
- R3: A write transaction stores the high byte of the extension register (offset 1, bits 15:8) into the slave register named by its low byte (bits 7:0).
- R4: A read transaction returns the addressed slave byte in bits 7:0 of the read-data register (offset 3), and bits 15:8 of the extension register have no effect on it.
- R5: Status bit 14 (read ready) is set when a read completes without error; it stays set until the host writes to the status register (offset 0) with bit 14 at 1, and a write with bit 14 at 0 leaves it set.
- R6: When the slave does not acknowledge a byte sent by the master, the transaction ends with a STOP, status bit 13 (error) is set and stays set until written with a 1 at bit 13, busy clears, and read ready is not set.
- R7: A command written while busy is set is ignored: it starts no second transaction and does not change the one in progress.
- R8: One SCL period lasts 4 x CLK_DIV clock cycles, and during address and data bits SDA changes only while SCL is low.
- R9: When no transaction is in progress both SCL and SDA are released (output enables at 0).
- R10: The extension register contents are captured when a command is accepted, so writing the extension register during a transaction does not change the bytes sent.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| regWrEn | input | 1 | Host register write strobe |
| regAddr | input | 2 | Host register offset: 0 status, 1 extension, 2 command, 3 read data |
| regWrData | input | 16 | Host write data |
| regRdData | output | 16 | Contents of the register selected by regAddr |
| sdaIn | input | 1 | Sensed level of the SDA line |
| sclOe | output | 1 | Pulls SCL low when 1 |
| sdaOe | output | 1 | Pulls SDA low when 1 |

## Verification
The bench hangs a behavioural slave on the open-drain lines and goes after the cases where a careless design would corrupt the peripheral. A command fired while a transfer runs, aimed at an absent slave, would either restart the bus mid-byte or raise a false error if it were not dropped; an extension write during the same transfer would put the wrong byte into the slave if the register were not captured at launch. A slave that never acknowledges must leave the error flag standing, the bus released and the ready flag clear, and a write-one-to-clear implemented as write-anything-clears would lose the ready flag on a status write of zero. The read path is checked with garbage in the unused extension byte, and the SCL period is measured against the divider so that a miscounted quarter phase would show up.

// File: rtl/i2cmb_pkg.sv
package i2cmb_pkg;

  // host register offsets
  localparam logic [1:0] REG_STATUS = 2'd0;
  localparam logic [1:0] REG_EXT    = 2'd1;
  localparam logic [1:0] REG_CMD    = 2'd2;
  localparam logic [1:0] REG_RDEXT  = 2'd3;

  // status and command bit positions
  localparam int BUSY_BIT  = 12;
  localparam int ERR_BIT   = 13;
  localparam int READY_BIT = 14;
  localparam int WRSEL_BIT = 10;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_BYTE,
    ST_RSTART,
    ST_STOP
  } seqState_t;

  typedef enum logic [1:0] {
    LD_ADDRW,
    LD_ADDRR,
    LD_REG,
    LD_DATA
  } loadSel_t;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic     busy;
    logic     loadShift;
    loadSel_t loadSel;
    logic     sample;
    logic     captureRd;
    logic     setErr;
    logic     setReady;
    logic     sclLow;
    logic     sdaLoad;
    logic     sdaLow;
    logic     dataBit;
  } ctrlStrb_t;

endpackage

// File: rtl/i2cmb_datapath.sv
module i2cmb_datapath
  import i2cmb_pkg::*;
#(
  parameter int CLK_DIV     = 8,
  parameter int SYNC_STAGES = 2,
  parameter int REG_W       = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWrEn,
  input  logic [1:0]       regAddr,
  input  logic [REG_W-1:0] regWrData,
  output logic [REG_W-1:0] regRdData,
  input  logic             sdaIn,
  input  ctrlStrb_t        strb,
  output logic             cmdGo,
  output logic             xferWrite,
  output logic             tick,
  output logic             shiftMsb,
  output logic             sdaBit,
  output logic             errQ,
  output logic             readyQ,
  output logic             sclOe,
  output logic             sdaOe
);

  localparam int BYTE_W = 8;
  localparam int ADDR_W = 7;
  localparam int DIV_W  = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(CLK_DIV - 1);

  logic [REG_W-1:0]       extQ;
  logic [REG_W-1:0]       cmdQ;
  logic [BYTE_W-1:0]      snapReg;
  logic [BYTE_W-1:0]      snapData;
  logic [ADDR_W-1:0]      slaveQ;
  logic                   writeQ;
  logic [BYTE_W-1:0]      shiftQ;
  logic [BYTE_W-1:0]      rdDataQ;
  logic [DIV_W-1:0]       divCnt;
  logic [SYNC_STAGES-1:0] sdaPipe;
  logic                   sclOeQ;
  logic                   sdaOeQ;

  wire statusWr = regWrEn && (regAddr == REG_STATUS);
  wire extWr    = regWrEn && (regAddr == REG_EXT);

  assign cmdGo = regWrEn && (regAddr == REG_CMD) &&
                 (regWrData[15:14] == 2'b11) && !strb.busy;

  // quarter-bit timebase, realigned on every launch
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divCnt <= '0;
    end else if (cmdGo || divCnt == DIV_LAST) begin
      divCnt <= '0;
    end else begin
      divCnt <= divCnt + 1'b1;
    end
  end
  assign tick = strb.busy && (divCnt == DIV_LAST);

  // input synchronizer for the sensed data line
  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) sdaPipe <= '1;
        else       sdaPipe <= sdaIn;
      end
    end else begin : g_syncN
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) sdaPipe <= '1;
        else       sdaPipe <= {sdaPipe[SYNC_STAGES-2:0], sdaIn};
      end
    end
  endgenerate
  assign sdaBit = sdaPipe[SYNC_STAGES-1];

  // host-visible registers and transfer snapshot
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      extQ     <= '0;
      cmdQ     <= '0;
      snapReg  <= '0;
      snapData <= '0;
      slaveQ   <= '0;
      writeQ   <= 1'b0;
    end else begin
      if (extWr) extQ <= regWrData;
      if (cmdGo) begin
        cmdQ     <= regWrData;
        snapReg  <= extQ[BYTE_W-1:0];
        snapData <= extQ[2*BYTE_W-1:BYTE_W];
        slaveQ   <= regWrData[ADDR_W:1];
        writeQ   <= regWrData[WRSEL_BIT];
      end
    end
  end
  assign xferWrite = writeQ;

  // shift register and received byte
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftQ  <= '0;
      rdDataQ <= '0;
    end else begin
      if (strb.loadShift) begin
        unique case (strb.loadSel)
          LD_ADDRW: shiftQ <= {slaveQ, 1'b0};
          LD_ADDRR: shiftQ <= {slaveQ, 1'b1};
          LD_REG:   shiftQ <= snapReg;
          default:  shiftQ <= snapData;
        endcase
      end else if (strb.sample) begin
        shiftQ <= {shiftQ[BYTE_W-2:0], sdaBit};
      end
      if (strb.captureRd) rdDataQ <= shiftQ;
    end
  end
  assign shiftMsb = shiftQ[BYTE_W-1];

  // sticky flags, set wins over a same-cycle clear
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      errQ   <= 1'b0;
      readyQ <= 1'b0;
    end else begin
      if (strb.setErr)                           errQ <= 1'b1;
      else if (statusWr && regWrData[ERR_BIT])   errQ <= 1'b0;
      if (strb.setReady)                         readyQ <= 1'b1;
      else if (statusWr && regWrData[READY_BIT]) readyQ <= 1'b0;
    end
  end

  // open-drain line drivers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclOeQ <= 1'b0;
      sdaOeQ <= 1'b0;
    end else begin
      sclOeQ <= strb.sclLow;
      if (strb.sdaLoad) sdaOeQ <= strb.sdaLow;
    end
  end
  assign sclOe = sclOeQ;
  assign sdaOe = sdaOeQ;

  always_comb begin
    regRdData = '0;
    unique case (regAddr)
      REG_STATUS: begin
        regRdData[BUSY_BIT]  = strb.busy;
        regRdData[ERR_BIT]   = errQ;
        regRdData[READY_BIT] = readyQ;
      end
      REG_EXT:   regRdData = extQ;
      REG_CMD:   regRdData = cmdQ;
      default:   regRdData[BYTE_W-1:0] = rdDataQ;
    endcase
  end

endmodule

// File: rtl/i2cmb_control.sv
module i2cmb_control
  import i2cmb_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      cmdGo,
  input  logic      xferWrite,
  input  logic      tick,
  input  logic      shiftMsb,
  input  logic      sdaBit,
  output ctrlStrb_t strb
);

  localparam logic [3:0] ACK_SLOT  = 4'd8;
  localparam logic [2:0] IDX_ADDRW = 3'd0;
  localparam logic [2:0] IDX_REG   = 3'd1;
  localparam logic [2:0] IDX_DATA  = 3'd2;
  localparam logic [2:0] IDX_ADDRR = 3'd3;
  localparam logic [2:0] IDX_RX    = 3'd4;

  seqState_t  state;
  logic [1:0] phase;
  logic [3:0] bitCnt;
  logic [2:0] byteIdx;
  logic       nackQ;
  logic       abortQ;

  wire slotEnd = tick && (phase == 2'd3);
  wire isRx    = (byteIdx == IDX_RX);
  wire byteEnd = (state == ST_BYTE) && slotEnd && (bitCnt == ACK_SLOT);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      phase   <= '0;
      bitCnt  <= '0;
      byteIdx <= IDX_ADDRW;
      nackQ   <= 1'b0;
      abortQ  <= 1'b0;
    end else begin
      if (tick) phase <= phase + 1'b1;
      unique case (state)
        ST_IDLE: begin
          if (cmdGo) begin
            state  <= ST_START;
            phase  <= '0;
            nackQ  <= 1'b0;
            abortQ <= 1'b0;
          end
        end
        ST_START: begin
          if (slotEnd) begin
            state   <= ST_BYTE;
            byteIdx <= IDX_ADDRW;
            bitCnt  <= '0;
          end
        end
        ST_BYTE: begin
          if (tick && phase == 2'd2 && bitCnt == ACK_SLOT && !isRx)
            nackQ <= sdaBit;
          if (slotEnd) begin
            if (bitCnt != ACK_SLOT) begin
              bitCnt <= bitCnt + 1'b1;
            end else begin
              bitCnt <= '0;
              if (nackQ) begin
                state  <= ST_STOP;
                abortQ <= 1'b1;
              end else begin
                unique case (byteIdx)
                  IDX_ADDRW: byteIdx <= IDX_REG;
                  IDX_REG: begin
                    if (xferWrite) byteIdx <= IDX_DATA;
                    else           state   <= ST_RSTART;
                  end
                  IDX_ADDRR: byteIdx <= IDX_RX;
                  default:   state   <= ST_STOP;
                endcase
              end
            end
          end
        end
        ST_RSTART: begin
          if (slotEnd) begin
            state   <= ST_BYTE;
            byteIdx <= IDX_ADDRR;
            bitCnt  <= '0;
          end
        end
        ST_STOP: begin
          if (slotEnd) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strb         = '0;
    strb.busy    = (state != ST_IDLE);
    strb.loadSel = LD_ADDRW;
    strb.sample  = (state == ST_BYTE) && tick && (phase == 2'd2) && (bitCnt != ACK_SLOT);
    strb.captureRd = byteEnd && isRx;
    strb.setErr    = byteEnd && nackQ;
    strb.setReady  = (state == ST_STOP) && slotEnd && !abortQ && !xferWrite;
    strb.dataBit   = (state == ST_BYTE);

    unique case (state)
      ST_START: begin
        strb.loadShift = slotEnd;
        strb.loadSel   = LD_ADDRW;
        strb.sdaLoad   = 1'b1;
        strb.sdaLow    = (phase != 2'd0);
        strb.sclLow    = (phase == 2'd3);
      end
      ST_RSTART: begin
        strb.loadShift = slotEnd;
        strb.loadSel   = LD_ADDRR;
        strb.sclLow    = (phase == 2'd0) || (phase == 2'd3);
        strb.sdaLoad   = (phase != 2'd0);
        strb.sdaLow    = (phase >= 2'd2);
      end
      ST_BYTE: begin
        strb.loadShift = byteEnd && !nackQ &&
                         (byteIdx == IDX_ADDRW || (byteIdx == IDX_REG && xferWrite));
        strb.loadSel   = (byteIdx == IDX_ADDRW) ? LD_REG : LD_DATA;
        strb.sclLow    = (phase < 2'd2);
        strb.sdaLoad   = (phase == 2'd1);
        strb.sdaLow    = (bitCnt != ACK_SLOT) && !isRx && !shiftMsb;
      end
      ST_STOP: begin
        strb.sclLow  = (phase < 2'd2);
        strb.sdaLoad = (phase != 2'd0);
        strb.sdaLow  = (phase != 2'd3);
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/i2c_mailbox_master.sv
module i2c_mailbox_master
  import i2cmb_pkg::*;
#(
  parameter int CLK_DIV     = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWrEn,
  input  logic [1:0]  regAddr,
  input  logic [15:0] regWrData,
  output logic [15:0] regRdData,
  input  logic        sdaIn,
  output logic        sclOe,
  output logic        sdaOe
);

  ctrlStrb_t strb;
  logic cmdGo;
  logic xferWrite;
  logic tick;
  logic shiftMsb;
  logic sdaBit;
  logic errQ;
  logic readyQ;
  logic busyW;
  logic dataBitW;

  assign busyW    = strb.busy;
  assign dataBitW = strb.dataBit;

  i2cmb_control u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .cmdGo     (cmdGo),
    .xferWrite (xferWrite),
    .tick      (tick),
    .shiftMsb  (shiftMsb),
    .sdaBit    (sdaBit),
    .strb      (strb)
  );

  i2cmb_datapath #(
    .CLK_DIV     (CLK_DIV),
    .SYNC_STAGES (SYNC_STAGES),
    .REG_W       (16)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .regWrEn   (regWrEn),
    .regAddr   (regAddr),
    .regWrData (regWrData),
    .regRdData (regRdData),
    .sdaIn     (sdaIn),
    .strb      (strb),
    .cmdGo     (cmdGo),
    .xferWrite (xferWrite),
    .tick      (tick),
    .shiftMsb  (shiftMsb),
    .sdaBit    (sdaBit),
    .errQ      (errQ),
    .readyQ    (readyQ),
    .sclOe     (sclOe),
    .sdaOe     (sdaOe)
  );

endmodule

// File: rtl/i2c_mailbox_master_sva.sv
module i2c_mailbox_master_sva (
  input logic        clk,
  input logic        rstN,
  input logic        regWrEn,
  input logic [1:0]  regAddr,
  input logic [15:0] regWrData,
  input logic        busy,
  input logic        dataBit,
  input logic        errFlag,
  input logic        readyFlag,
  input logic        sclOe,
  input logic        sdaOe
);

  wire validCmd = regWrEn && (regAddr == 2'd2) && (regWrData[15:14] == 2'b11);
  wire statusWr = regWrEn && (regAddr == 2'd0);

  // R2: an accepted command raises busy on the next cycle
  assert_launch_R2: assert property (@(posedge clk) disable iff (!rstN)
    (validCmd && !busy) |=> busy);

  // R2: without a valid command the block stays idle
  assert_stay_idle_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !validCmd) |=> !busy);

  // R9: both lines released whenever idle
  assert_idle_released_R9: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!sclOe && !sdaOe));

  // R8: SDA holds while SCL is high during address and data bits
  assert_sda_stable_R8: assert property (@(posedge clk) disable iff (!rstN)
    ($past(dataBit) && $past(dataBit, 2) && !sclOe && !$past(sclOe))
      |-> (sdaOe == $past(sdaOe)));

  // R6: error flag is sticky until written with a one
  assert_err_sticky_R6: assert property (@(posedge clk) disable iff (!rstN)
    (errFlag && !(statusWr && regWrData[13])) |=> errFlag);

  // R5: ready flag is sticky until written with a one
  assert_ready_sticky_R5: assert property (@(posedge clk) disable iff (!rstN)
    (readyFlag && !(statusWr && regWrData[14])) |=> readyFlag);

endmodule

bind i2c_mailbox_master i2c_mailbox_master_sva u_sva (
  .clk       (clk),
  .rstN      (rstN),
  .regWrEn   (regWrEn),
  .regAddr   (regAddr),
  .regWrData (regWrData),
  .busy      (busyW),
  .dataBit   (dataBitW),
  .errFlag   (errQ),
  .readyFlag (readyQ),
  .sclOe     (sclOe),
  .sdaOe     (sdaOe)
);

// File: tb/i2c_mailbox_master_tb.sv
`timescale 1ns/1ps
module i2c_mailbox_master_tb;

  localparam int CLK_DIV = 8;
  localparam logic [6:0] SLV_ADDR = 7'h2A;
  localparam logic [6:0] BAD_ADDR = 7'h33;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [1:0]  regAddr = 2'd0;
  logic [15:0] regWrData = 16'h0;
  logic [15:0] regRdData;
  logic        sclOe;
  logic        sdaOe;
  logic        slvDrive = 1'b0;

  wire sclLine = ~sclOe;
  wire sdaLine = ~(sdaOe | slvDrive);

  int checkCnt = 0;
  int failCnt = 0;
  bit doneFlag = 1'b0;

  always #2 clk = ~clk;

  i2c_mailbox_master #(.CLK_DIV(CLK_DIV)) u_dut (
    .clk       (clk),
    .rstN      (rstN),
    .regWrEn   (regWrEn),
    .regAddr   (regAddr),
    .regWrData (regWrData),
    .regRdData (regRdData),
    .sdaIn     (sdaLine),
    .sclOe     (sclOe),
    .sdaOe     (sdaOe)
  );

  // ---------------- behavioural slave ----------------
  logic [7:0] mem [0:255];
  logic [7:0] sh = 8'h0;
  logic [7:0] txByte = 8'h0;
  logic [7:0] ptr = 8'h0;
  int  sBit = 0;
  int  byteCnt = 0;
  bit  inAck = 0;
  bit  matched = 0;
  bit  txMode = 0;
  bit  pendTx = 0;

  function automatic logic [7:0] initVal(int i);
    return 8'((i * 3 + 7) & 255);
  endfunction

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = initVal(i);
  end

  task automatic slaveReset();
    sBit = 0; byteCnt = 0; inAck = 0; matched = 0;
    txMode = 0; pendTx = 0; slvDrive = 1'b0;
  endtask

  always @(negedge sdaLine) if (sclLine === 1'b1) slaveReset();
  always @(posedge sdaLine) if (sclLine === 1'b1) slaveReset();

  always @(posedge sclLine) begin
    if (!inAck) begin
      sh = {sh[6:0], sdaLine};
      sBit++;
    end
  end

  always @(negedge sclLine) begin
    if (inAck) begin
      inAck = 0; sBit = 0; byteCnt++;
      slvDrive = 1'b0;
      if (pendTx) begin
        pendTx = 0;
        slvDrive = ~txByte[7];
      end
    end else if (sBit == 8) begin
      inAck = 1;
      slvDrive = 1'b0;
      if (byteCnt == 0) begin
        matched = (sh[7:1] == SLV_ADDR);
        if (matched) begin
          slvDrive = 1'b1;
          if (sh[0]) begin
            txMode = 1; pendTx = 1; txByte = mem[ptr];
          end
        end
      end else if (matched && !txMode) begin
        if (byteCnt == 1) ptr = sh;
        else begin
          mem[ptr] = sh; ptr = ptr + 8'd1;
        end
        slvDrive = 1'b1;
      end
    end else if (txMode && sBit > 0 && sBit < 8) begin
      slvDrive = ~txByte[7 - sBit];
    end
  end

  // ---------------- helpers ----------------
  task automatic check(bit ok, string req, string what, int act, int exp);
    checkCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic regWrite(logic [1:0] a, logic [15:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0; regWrData = 16'h0;
  endtask

  task automatic regRead(logic [1:0] a, output logic [15:0] d);
    @(negedge clk);
    regAddr = a;
    #1;
    d = regRdData;
  endtask

  task automatic waitIdle();
    logic [15:0] s;
    for (int i = 0; i < 20000; i++) begin
      regRead(2'd0, s);
      if (!s[12]) return;
    end
  endtask

  task automatic finishRun();
    if (!doneFlag) begin
      doneFlag = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checkCnt, failCnt);
      $finish;
    end
  endtask

  // ---------------- scenarios ----------------
  task automatic testReset();
    logic [15:0] v;
    regRead(2'd0, v);
    check(v == 16'h0, "R1", "status after reset", v, 0);
    regRead(2'd3, v);
    check(v == 16'h0, "R1", "read data after reset", v, 0);
    check(!sclOe && !sdaOe, "R9", "lines after reset", {sclOe, sdaOe}, 0);
  endtask

  task automatic testWrite();
    logic [15:0] v;
    regWrite(2'd1, {8'hC3, 8'h20});
    regWrite(2'd2, 16'hC400 | {8'h0, SLV_ADDR, 1'b0});
    regRead(2'd0, v);
    check(v[12] == 1'b1, "R1", "busy after launch", v[12], 1);
    waitIdle();
    check(mem[8'h20] == 8'hC3, "R3", "slave byte written", mem[8'h20], 8'hC3);
    regRead(2'd0, v);
    check(v == 16'h0, "R3", "status after write", v, 0);
    check(!sclOe && !sdaOe, "R9", "lines after write", {sclOe, sdaOe}, 0);
  endtask

  task automatic testRead();
    logic [15:0] v;
    regWrite(2'd1, {8'hFF, 8'h22});
    regWrite(2'd2, 16'hC000 | {8'h0, SLV_ADDR, 1'b0});
    waitIdle();
    regRead(2'd3, v);
    check(v[7:0] == initVal(8'h22), "R4", "read byte", v[7:0], initVal(8'h22));
    check(mem[8'h22] == initVal(8'h22), "R4", "slave untouched by read", mem[8'h22], initVal(8'h22));
    regRead(2'd0, v);
    check(v[14] == 1'b1 && v[13] == 1'b0, "R5", "ready set after read", v, 16'h4000);
    regWrite(2'd0, 16'h0000);
    regRead(2'd0, v);
    check(v[14] == 1'b1, "R5", "ready kept on zero write", v[14], 1);
    regWrite(2'd0, 16'h4000);
    regRead(2'd0, v);
    check(v[14] == 1'b0, "R5", "ready cleared by one", v[14], 0);
  endtask

  task automatic testReadAfterWrite();
    logic [15:0] v;
    regWrite(2'd1, {8'h00, 8'h20});
    regWrite(2'd2, 16'hC000 | {8'h0, SLV_ADDR, 1'b0});
    waitIdle();
    regRead(2'd3, v);
    check(v[7:0] == 8'hC3, "R4", "read back written byte", v[7:0], 8'hC3);
    regWrite(2'd0, 16'h4000);
  endtask

  task automatic testNack();
    logic [15:0] v;
    regWrite(2'd1, {8'h99, 8'h40});
    regWrite(2'd2, 16'hC400 | {8'h0, BAD_ADDR, 1'b0});
    waitIdle();
    regRead(2'd0, v);
    check(v[13] == 1'b1, "R6", "error after nack", v[13], 1);
    check(v[12] == 1'b0 && v[14] == 1'b0, "R6", "busy and ready clear", v, 16'h2000);
    check(mem[8'h40] == initVal(8'h40), "R6", "slave unchanged", mem[8'h40], initVal(8'h40));
    check(!sclOe && !sdaOe, "R9", "lines after abort", {sclOe, sdaOe}, 0);
    regWrite(2'd0, 16'h4000);
    regRead(2'd0, v);
    check(v[13] == 1'b1, "R6", "error kept on other bit", v[13], 1);
    regWrite(2'd0, 16'h2000);
    regRead(2'd0, v);
    check(v[13] == 1'b0, "R6", "error cleared by one", v[13], 0);
  endtask

  task automatic testBusyIgnore();
    logic [15:0] v;
    regWrite(2'd1, {8'h55, 8'h10});
    regWrite(2'd2, 16'hC400 | {8'h0, SLV_ADDR, 1'b0});
    repeat (40) @(negedge clk);
    regWrite(2'd1, {8'h77, 8'h11});
    regWrite(2'd2, 16'hC400 | {8'h0, BAD_ADDR, 1'b0});
    waitIdle();
    check(mem[8'h10] == 8'h55, "R10", "snapshot byte stored", mem[8'h10], 8'h55);
    check(mem[8'h11] == initVal(8'h11), "R7", "no second write", mem[8'h11], initVal(8'h11));
    regRead(2'd0, v);
    check(v[13] == 1'b0, "R7", "no error from ignored cmd", v[13], 0);
    repeat (200) @(negedge clk);
    regRead(2'd0, v);
    check(v[12] == 1'b0, "R7", "no transfer started later", v[12], 0);
  endtask

  task automatic testBadCmd();
    logic [15:0] v;
    regWrite(2'd2, 16'h4400 | {8'h0, SLV_ADDR, 1'b0});
    regRead(2'd0, v);
    check(v[12] == 1'b0, "R2", "bit15 clear ignored", v[12], 0);
    regWrite(2'd2, 16'h8400 | {8'h0, SLV_ADDR, 1'b0});
    regRead(2'd0, v);
    check(v[12] == 1'b0, "R2", "bit14 clear ignored", v[12], 0);
    check(!sclOe && !sdaOe, "R9", "lines after bad cmd", {sclOe, sdaOe}, 0);
  endtask

  task automatic testSclPeriod();
    int edges = 0;
    int cnt = 0;
    int period = 0;
    logic prev;
    regWrite(2'd1, {8'h3C, 8'h30});
    regWrite(2'd2, 16'hC400 | {8'h0, SLV_ADDR, 1'b0});
    prev = sclOe;
    for (int i = 0; i < 2000 && edges < 3; i++) begin
      @(negedge clk);
      cnt++;
      if (sclOe && !prev) begin
        edges++;
        if (edges == 3) period = cnt;
        cnt = 0;
      end
      prev = sclOe;
    end
    check(period == 4 * CLK_DIV, "R8", "SCL period in cycles", period, 4 * CLK_DIV);
    waitIdle();
    check(mem[8'h30] == 8'h3C, "R8", "byte intact at this rate", mem[8'h30], 8'h3C);
  endtask

  initial begin
    #(4 * 150000);
    failCnt++;
    $display("FAIL watchdog: run did not finish, actual timeout expected completion");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    testReset();
    testWrite();
    testRead();
    testReadAfterWrite();
    testNack();
    testBusyIgnore();
    testBadCmd();
    testSclPeriod();
    repeat (10) @(negedge clk);
    finishRun();
  end

endmodule